// File: doc/BRIEF.md
# Processor Supervisor with Watchdog

This block is the digital core of a processor supervisor. It watches a low-supply flag from an external comparator, an active-low manual-reset request, a watchdog kick line with its own "watchdog disabled" qualifier, and a power-fail comparator flag. It drives three active-low outputs: a processor reset, a watchdog alarm and a power-fail warning. Every input is asynchronous. Each one passes through a two-stage synchronizer before any logic uses it.

The reset output is held low while the supply is low or manual reset is pressed. After the last such condition clears, it stays low for a further `STRETCH_CYC` clock cycles. The watchdog alarm goes low when the kick line has held one level for `TIMEOUT_CYC` cycles, and it stays latched until the watchdog is cleared. A low supply also forces the alarm low, and the alarm comes back high as soon as the supply recovers, with no stretching. A watchdog expiry never resets the processor by itself. Systems that want that behaviour wire the alarm back into manual reset outside the block.

Top module: `cpu_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is low and the watchdog is cleared. After `rst_n` rises with the supply good and manual reset released, `rst_out_n` is low at clock edge STRETCH_CYC+1 and high at edge STRETCH_CYC+2, counting edges from the release.
- R2: While `supply_low_i` is 1, `rst_out_n` is low from the third clock edge onward and stays low for as long as the flag stays 1, however long that is.
- R3: When `supply_low_i` returns to 0, `rst_out_n` is still low at edge STRETCH_CYC+1 after the change and is high at edge STRETCH_CYC+2.
- R4: When `mr_n_i` is 0, `rst_out_n` is driven low. After `mr_n_i` returns to 1, the same STRETCH_CYC+2 edge stretch applies. A new press during the stretch restarts the stretch from its own release.
- R5: When the kick line changes level (rising or falling) and no other clear happens, `wdo_n` is still high at edge TIMEOUT_CYC+2 after the change and goes low at edge TIMEOUT_CYC+3.
- R6: After an expiry, `wdo_n` stays low until a clear occurs. A clear is a kick edge, the disable qualifier, or an asserted `rst_out_n`. A kick edge or disable raises `wdo_n` at the third edge after the input change. A manual-reset press raises it at the fourth edge.
- R7: While `wd_off_i` is 1, the watchdog counter stays cleared and `wdo_n` stays high, whatever the kick line does.
- R8: `supply_low_i` at 1 forces `wdo_n` low from the second edge. When the flag returns to 0, `wdo_n` is still low at the first edge and high at the second, with no minimum width.
- R9: A watchdog expiry leaves `rst_out_n` high.
- R10: `pfo_n` equals the inverse of `pfail_i` as it was two clock edges earlier (1 on `pfail_i` means the monitored input is below its threshold).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all intervals count its rising edges |
| rst_n | input | 1 | Synchronous active-low power-on reset of the block |
| supply_low_i | input | 1 | 1 when the supply comparator sees the supply below the reset threshold (asynchronous) |
| mr_n_i | input | 1 | Active-low manual reset request (asynchronous) |
| wd_kick_i | input | 1 | Watchdog kick; any level change restarts the timeout (asynchronous) |
| wd_off_i | input | 1 | 1 when the kick line is left floating, which disables the watchdog (asynchronous) |
| pfail_i | input | 1 | 1 when the power-fail comparator sees its input below threshold (asynchronous) |
| rst_out_n | output | 1 | Active-low processor reset with minimum width |
| wdo_n | output | 1 | Active-low watchdog alarm, latched on expiry, also low on low supply |
| pfo_n | output | 1 | Active-low power-fail warning |

## Verification
The assertions assume that each input level is held for at least one full clock period, so the synchronizer sees every level the stimulus means to apply. Stretch and timeout checks count from the first edge at which the synchronized level is seen. The bench changes inputs only on falling clock edges and never changes them within one period. Every pulse it applies lasts at least three cycles. It uses short stretch and timeout values so that each interval can be checked to the exact edge.

// File: rtl/sup_pkg.sv
// Shared definitions for the processor supervisor.
// Assumes: two synchronizer stages are enough for the board's input rates.
package sup_pkg;
    localparam int SYNC_STAGES = 2;

    // Bundle of asynchronous inputs, synchronized together.
    typedef struct packed {
        logic supply_low;
        logic mr_n;
        logic kick;
        logic wd_off;
        logic pfail;
    } sup_in_t;

    // Value the synchronizer holds in reset: every input reads as "unsafe".
    localparam sup_in_t SAFE_IN = '{supply_low: 1'b1, mr_n: 1'b0, kick: 1'b0,
                                    wd_off: 1'b1, pfail: 1'b1};

    typedef enum logic [1:0] {RG_HOLD, RG_STRETCH, RG_RUN} rg_state_e;

    // Counter width for a count that reaches n-1.
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/sup_sync.sv
// Multi-stage level synchronizer for a bundle of asynchronous inputs.
// Assumes STAGES >= 2 and that every input level lasts at least one clock.
module sup_sync #(
    parameter int WIDTH = 5,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the input through the stage chain; reset loads the safe value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_rst_stretch.sv
// Reset pulse generator: holds reset while 'hold' is high, then keeps it
// for STRETCH_CYC more edges. A new hold restarts the stretch.
// Assumes 'hold' is already synchronous and STRETCH_CYC >= 1.
module sup_rst_stretch
    import sup_pkg::*;
#(
    parameter int STRETCH_CYC = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic rst_active
);
    localparam int CW = cnt_bits(STRETCH_CYC);
    localparam logic [CW-1:0] LAST = CW'(STRETCH_CYC - 1);

    rg_state_e     state;
    logic [CW-1:0] cnt;

    // State and stretch counter; the count starts at 0 on each hold.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            state <= RG_HOLD;
            cnt   <= '0;
        end else if (state != RG_RUN) begin
            if (cnt == LAST) begin
                state <= RG_RUN;
                cnt   <= '0;
            end else begin
                state <= RG_STRETCH;
                cnt   <= cnt + 1'b1;
            end
        end
    end

    // Reset is asserted in every state except the run state.
    always_comb rst_active = (state != RG_RUN);
endmodule

// File: rtl/sup_wdog.sv
// Watchdog timer: expires after TIMEOUT_CYC edges without a kick edge and
// latches until cleared by a kick edge, the disable qualifier or reset.
// Assumes kick_s and wd_off_s come from the synchronizer and TIMEOUT_CYC >= 2.
module sup_wdog
    import sup_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_s,
    input  logic wd_off_s,
    input  logic cpu_rst,
    output logic kick_edge,
    output logic expired
);
    localparam int CW = cnt_bits(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic          kick_d;
    logic [CW-1:0] cnt;
    logic          clr;

    // Delay the synchronized kick for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) kick_d <= 1'b0;
        else        kick_d <= kick_s;
    end

    // Detect either polarity of kick and gather every clear source.
    always_comb begin
        kick_edge = kick_s ^ kick_d;
        clr       = kick_edge | wd_off_s | cpu_rst;
    end

    // Timeout counter with latched expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (!expired) begin
            if (cnt == LAST) expired <= 1'b1;
            else             cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cpu_supervisor.sv
// Processor supervisor top: synchronizes the inputs, builds the stretched
// reset, runs the watchdog and drives the three active-low outputs.
// Assumes all inputs are asynchronous levels held for at least one clock.
module cpu_supervisor
    import sup_pkg::*;
#(
    parameter int STRETCH_CYC = 200000,
    parameter int TIMEOUT_CYC = 1600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    input  logic mr_n_i,
    input  logic wd_kick_i,
    input  logic wd_off_i,
    input  logic pfail_i,
    output logic rst_out_n,
    output logic wdo_n,
    output logic pfo_n
);
    sup_in_t raw_in;
    sup_in_t syn_in;
    logic    supply_low_s;
    logic    mr_n_s;
    logic    wd_off_s;
    logic    kick_s;
    logic    pfail_s;
    logic    rst_active;
    logic    kick_edge;
    logic    wd_expired;

    // Bundle the raw inputs for the synchronizer.
    always_comb begin
        raw_in.supply_low = supply_low_i;
        raw_in.mr_n       = mr_n_i;
        raw_in.kick       = wd_kick_i;
        raw_in.wd_off     = wd_off_i;
        raw_in.pfail      = pfail_i;
    end

    sup_sync #(
        .WIDTH  ($bits(sup_in_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SAFE_IN)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (syn_in)
    );

    // Unpack the synchronized bundle.
    always_comb begin
        supply_low_s = syn_in.supply_low;
        mr_n_s       = syn_in.mr_n;
        kick_s       = syn_in.kick;
        wd_off_s     = syn_in.wd_off;
        pfail_s      = syn_in.pfail;
    end

    sup_rst_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (supply_low_s | ~mr_n_s),
        .rst_active(rst_active)
    );

    sup_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick_s   (kick_s),
        .wd_off_s (wd_off_s),
        .cpu_rst  (rst_active),
        .kick_edge(kick_edge),
        .expired  (wd_expired)
    );

    // Drive the active-low outputs; the alarm follows low supply unstretched.
    always_comb begin
        rst_out_n = ~rst_active;
        wdo_n     = ~(wd_expired | supply_low_s);
        pfo_n     = ~pfail_s;
    end
endmodule

// File: rtl/sup_checker.sv
// Property checker for cpu_supervisor, attached by bind below.
// Assumes input levels last at least one clock period.
module sup_checker #(
    parameter int STRETCH_CYC = 200000
) (
    input logic clk,
    input logic rst_n,
    input logic supply_low_i,
    input logic pfail_i,
    input logic supply_low_s,
    input logic mr_n_s,
    input logic wd_off_s,
    input logic kick_edge,
    input logic wd_expired,
    input logic rst_out_n,
    input logic wdo_n,
    input logic pfo_n
);
    localparam int QW = $clog2(STRETCH_CYC + 1);
    localparam logic [QW-1:0] QMAX = QW'(STRETCH_CYC);

    logic [QW-1:0] quiet_cnt;

    // Count consecutive edges with no reset hold, saturating at the stretch.
    always_ff @(posedge clk) begin
        if (!rst_n || supply_low_s || !mr_n_s) quiet_cnt <= '0;
        else if (quiet_cnt != QMAX)            quiet_cnt <= quiet_cnt + 1'b1;
    end

    AST_HOLD_ASSERTS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_low_s || !mr_n_s) |=> !rst_out_n); // R2

    AST_STRETCH_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> (quiet_cnt >= QMAX)); // R3

    AST_LOWLINE_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2) && $past(supply_low_i, 2)) |-> !wdo_n); // R8

    AST_ALARM_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expired && !kick_edge && !wd_off_s && rst_out_n) |=> !wdo_n); // R6

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wd_off_s |=> !wd_expired); // R7

    AST_EXPIRY_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wdo_n) && !supply_low_s && !$past(supply_low_s) && $past(mr_n_s))
        |-> rst_out_n); // R9

    AST_PFO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2)) |-> (pfo_n == !$past(pfail_i, 2))); // R10
endmodule

bind cpu_supervisor sup_checker #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_low_i(supply_low_i),
    .pfail_i     (pfail_i),
    .supply_low_s(supply_low_s),
    .mr_n_s      (mr_n_s),
    .wd_off_s    (wd_off_s),
    .kick_edge   (kick_edge),
    .wd_expired  (wd_expired),
    .rst_out_n   (rst_out_n),
    .wdo_n       (wdo_n),
    .pfo_n       (pfo_n)
);

// File: tb/tb_cpu_supervisor.sv
`timescale 1ns/1ps
module tb_cpu_supervisor;
    localparam int S = 20;
    localparam int T = 40;

    logic clk = 1'b0;
    logic rst_n, supply_low_i, mr_n_i, wd_kick_i, wd_off_i, pfail_i;
    logic rst_out_n, wdo_n, pfo_n;
    int   n_chk = 0;
    int   n_bad = 0;

    // Vector bits: [3] supply_low, [2] pfail, [1] expected wdo_n, [0] expected pfo_n
    localparam logic [3:0] VEC [8] = '{4'b0011, 4'b0110, 4'b1100, 4'b1001,
                                       4'b0011, 4'b1100, 4'b0110, 4'b0011};

    always #2.5 clk = ~clk;

    cpu_supervisor #(.STRETCH_CYC(S), .TIMEOUT_CYC(T)) dut (
        .clk(clk), .rst_n(rst_n), .supply_low_i(supply_low_i), .mr_n_i(mr_n_i),
        .wd_kick_i(wd_kick_i), .wd_off_i(wd_off_i), .pfail_i(pfail_i),
        .rst_out_n(rst_out_n), .wdo_n(wdo_n), .pfo_n(pfo_n)
    );

    // Wait n rising edges, then settle at the following falling edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; supply_low_i = 0; mr_n_i = 1; wd_kick_i = 0; wd_off_i = 0; pfail_i = 0;
        @(negedge clk);
        tick(3);
        chk("R1 reset asserted during rst_n", rst_out_n, 1'b0);
        rst_n = 1;
        tick(S + 1);
        chk("R1 still in power-on stretch", rst_out_n, 1'b0);
        tick(1);
        chk("R1 power-on stretch ends", rst_out_n, 1'b1);

        // Table walk: supply and power-fail combinations (R8, R10, R2)
        foreach (VEC[i]) begin
            supply_low_i = VEC[i][3];
            pfail_i      = VEC[i][2];
            tick(3);
            chk("R8 wdo_n vector", wdo_n, VEC[i][1]);
            chk("R10 pfo_n vector", pfo_n, VEC[i][0]);
            if (VEC[i][3]) chk("R2 reset on low supply", rst_out_n, 1'b0);
        end
        tick(S + 5);
        chk("R3 reset released after table", rst_out_n, 1'b1);

        // Supply recovery timing (R3, R8)
        supply_low_i = 1;
        tick(5);
        chk("R2 reset low", rst_out_n, 1'b0);
        chk("R8 alarm low", wdo_n, 1'b0);
        supply_low_i = 0;
        tick(1);
        chk("R8 alarm still syncing", wdo_n, 1'b0);
        tick(1);
        chk("R8 alarm high, no stretch", wdo_n, 1'b1);
        chk("R3 reset still low", rst_out_n, 1'b0);
        tick(S - 1);
        chk("R3 reset low at edge S+1", rst_out_n, 1'b0);
        tick(1);
        chk("R3 reset high at edge S+2", rst_out_n, 1'b1);

        // Manual reset and restart (R4)
        mr_n_i = 0;
        tick(3);
        chk("R4 manual reset asserts", rst_out_n, 1'b0);
        mr_n_i = 1;
        tick(10);
        chk("R4 in stretch", rst_out_n, 1'b0);
        mr_n_i = 0;
        tick(3);
        mr_n_i = 1;
        tick(S + 1);
        chk("R4 stretch restarted", rst_out_n, 1'b0);
        tick(1);
        chk("R4 stretch ends", rst_out_n, 1'b1);

        // Expiry after rising kick (R5, R9)
        wd_kick_i = 1;
        tick(T + 2);
        chk("R5 not yet expired", wdo_n, 1'b1);
        tick(1);
        chk("R5 expired after rising kick", wdo_n, 1'b0);
        chk("R9 expiry leaves reset high", rst_out_n, 1'b1);
        tick(2 * T);
        chk("R6 alarm stays latched", wdo_n, 1'b0);
        chk("R9 reset still high", rst_out_n, 1'b1);

        // Falling kick clears, then times out again (R6, R5)
        wd_kick_i = 0;
        tick(2);
        chk("R6 still latched before clear", wdo_n, 1'b0);
        tick(1);
        chk("R6 falling kick clears", wdo_n, 1'b1);
        tick(T - 1);
        chk("R5 falling: not yet expired", wdo_n, 1'b1);
        tick(1);
        chk("R5 falling: expired", wdo_n, 1'b0);

        // Regular kicking keeps the alarm high (R5)
        for (int k = 0; k < 6; k++) begin
            wd_kick_i = ~wd_kick_i;
            tick(T - 5);
            chk("R5 kicked in time", wdo_n, 1'b1);
        end

        // Disable qualifier (R7)
        wd_off_i = 1;
        tick(3 * T);
        chk("R7 disabled stays high", wdo_n, 1'b1);
        wd_off_i = 0;
        tick(T + 5);
        chk("R5 expires after enable", wdo_n, 1'b0);
        wd_off_i = 1;
        tick(2);
        chk("R7 latched before disable seen", wdo_n, 1'b0);
        tick(1);
        chk("R7 disable clears alarm", wdo_n, 1'b1);

        // Reset clears the latched alarm (R6)
        wd_off_i = 0;
        tick(T + 5);
        chk("R6 expired again", wdo_n, 1'b0);
        mr_n_i = 0;
        tick(3);
        chk("R6 latched at edge 3", wdo_n, 1'b0);
        tick(1);
        chk("R6 reset clears alarm", wdo_n, 1'b1);
        mr_n_i = 1;
        tick(S + 2);
        chk("R4 released", rst_out_n, 1'b1);

        // Power-fail latency (R10)
        pfail_i = 1;
        tick(1);
        chk("R10 pfo_n before sync", pfo_n, 1'b1);
        tick(1);
        chk("R10 pfo_n low", pfo_n, 1'b0);
        pfail_i = 0;
        tick(2);
        chk("R10 pfo_n high", pfo_n, 1'b1);

        // Long low supply holds reset (R2)
        supply_low_i = 1;
        tick(3 * S);
        chk("R2 reset held through long low", rst_out_n, 1'b0);
        supply_low_i = 0;
        tick(2);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule